// File: doc/BRIEF.md
# Two-Beat Fallback Link Adapter for Vertical Die-to-Die Wires

This block carries flits across a bundle of vertical die-to-die wires. It has a transmit side, the wire bundle and a receive side. With all wires healthy, a flit crosses the bundle in one cycle on the full wire set. If defects show up in the data wires, either at manufacture or in the field, the link is switched to a serial mode. In that mode each flit crosses as two halves, in two consecutive cycles, over whichever half of the bundle is still sound. The receive side joins the halves and emits the whole flit. Links without faults stay in full-width mode.

The upstream router uses a valid/ready handshake to hand flits to the transmit side. In serial mode, ready drops for the cycle that carries the second half, so nothing new is taken while a transfer is under way. Two configuration inputs choose the mode and the healthy half. A new configuration is applied only at a clock edge where the link carries nothing. A defect input marks wires as dead, and a dead wire reads as zero at the receiver. This input lets the block's use of the wires be observed. The flow-control sideband is treated as already protected.

Top module: `serlink_adapter`

## Requirements
- R1: Reset is asynchronous and active low. After reset, `in_ready_o` is 1, `out_valid_o` is 0, and the active configuration is full-width mode using the low half.
- R2: In full-width mode, a flit taken at clock edge E appears on `out_data_o` with `out_valid_o` high after edge E+1. A flit can be taken on every cycle.
- R3: In serial mode, a flit taken at edge E appears whole with `out_valid_o` high after edge E+2. The first beat carries bits [W/2-1:0] of the flit and the second beat carries bits [W-1:W/2].
- R4: After a flit is taken in serial mode, `in_ready_o` is 0 for exactly one cycle. In full-width mode `in_ready_o` never drops.
- R5: In serial mode, `cfg_use_hi_i`=0 carries the beats on wires [W/2-1:0] and `cfg_use_hi_i`=1 carries them on wires [W-1:W/2]. Dead wires in the unused half have no effect on delivered data.
- R6: A wire whose bit is 1 in `wire_dead_i` is received as 0. In full-width mode this clears that bit of the flit. In serial mode it clears that bit position within both halves.
- R7: `cfg_serial_i` and `cfg_use_hi_i` take effect only at an edge where no second beat is pending, the wires carry no beat, and `in_valid_i` is 0. At every other edge the active configuration is held.
- R8: In serial mode, a flit offered continuously is taken every second cycle. Flits are delivered in the order taken, with at least one idle output cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_serial_i | input | 1 | Requested mode: 1 = two-beat serial, 0 = full width |
| cfg_use_hi_i | input | 1 | Requested healthy half for serial mode: 0 = low wires, 1 = high wires |
| wire_dead_i | input | W | Defect model: 1 marks a dead wire that reads as zero |
| in_valid_i | input | 1 | Upstream flit valid |
| in_data_i | input | W | Upstream flit |
| in_ready_o | output | 1 | Adapter can take a flit this cycle |
| out_valid_o | output | 1 | Delivered flit valid (one cycle) |
| out_data_o | output | W | Delivered flit |

## Verification
Back-to-back full-width streams of all-ones, all-zeros, alternating and walking-one words show whether every bit lane is routed and whether single-cycle throughput holds. The same words sent serially, with the valid held high, tell a swapped or misplaced half apart from a stall or ordering fault. Dead wires are placed in the unused half and then in the used half, once for each half choice, which separates correct wire selection from data that only arrives right by chance. A configuration change requested in the middle of a stream and then again during a gap shows whether the change waits for an idle edge.

// File: rtl/serlink_pkg.sv
package serlink_pkg;
  // Sideband tag carried alongside the wire bundle each cycle
  typedef enum logic [1:0] {
    LK_IDLE   = 2'd0,
    LK_FULL   = 2'd1,
    LK_FIRST  = 2'd2,
    LK_SECOND = 2'd3
  } link_kind_e;
endpackage

// File: rtl/serlink_mode.sv
module serlink_mode (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_serial_i,
  input  logic cfg_use_hi_i,
  input  logic quiet_i,
  output logic mode_ser_o,
  output logic mode_hi_o
);
  logic ser_q, hi_q, ser_d, hi_d;

  always_comb begin
    ser_d = ser_q;
    hi_d  = hi_q;
    if (quiet_i) begin
      ser_d = cfg_serial_i;
      hi_d  = cfg_use_hi_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ser_q <= 1'b0;
      hi_q  <= 1'b0;
    end else begin
      ser_q <= ser_d;
      hi_q  <= hi_d;
    end
  end

  assign mode_ser_o = ser_q;
  assign mode_hi_o  = hi_q;
endmodule

// File: rtl/serlink_tx.sv
module serlink_tx
  import serlink_pkg::*;
#(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           mode_ser_i,
  input  logic           mode_hi_i,
  input  logic           in_valid_i,
  input  logic [W-1:0]   in_data_i,
  output logic           in_ready_o,
  output logic           pend_o,
  output link_kind_e     kind_o,
  output logic [W-1:0]   wires_o
);
  localparam int H = W / 2;

  logic           pend_q, pend_d;
  logic [H-1:0]   hold_q, hold_d;
  logic           hold_en;
  link_kind_e     kind_q, kind_d;
  logic [W-1:0]   wires_q, wires_d;
  logic           wires_en;
  logic           accept;

  function automatic logic [W-1:0] place(input logic [H-1:0] x, input logic hi);
    return hi ? {x, {H{1'b0}}} : {{H{1'b0}}, x};
  endfunction

  always_comb begin
    accept   = in_valid_i & ~pend_q;
    pend_d   = accept & mode_ser_i;
    hold_en  = accept & mode_ser_i;
    hold_d   = in_data_i[W-1:H];
    wires_en = accept | pend_q;
    kind_d   = LK_IDLE;
    wires_d  = wires_q;
    if (pend_q) begin
      kind_d  = LK_SECOND;
      wires_d = place(hold_q, mode_hi_i);
    end else if (accept && mode_ser_i) begin
      kind_d  = LK_FIRST;
      wires_d = place(in_data_i[H-1:0], mode_hi_i);
    end else if (accept) begin
      kind_d  = LK_FULL;
      wires_d = in_data_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      kind_q <= LK_IDLE;
    end else begin
      pend_q <= pend_d;
      kind_q <= kind_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= '0;
      wires_q <= '0;
    end else begin
      if (hold_en)  hold_q  <= hold_d;
      if (wires_en) wires_q <= wires_d;
    end
  end

  assign in_ready_o = ~pend_q;
  assign pend_o     = pend_q;
  assign kind_o     = kind_q;
  assign wires_o    = wires_q;
endmodule

// File: rtl/serlink_chan.sv
module serlink_chan #(
  parameter int W = 32
) (
  input  logic [W-1:0] tx_wires_i,
  input  logic [W-1:0] dead_i,
  output logic [W-1:0] rx_wires_o
);
  // One vertical wire per bit; a dead wire reads as zero
  for (genvar i = 0; i < W; i++) begin : g_wire
    assign rx_wires_o[i] = tx_wires_i[i] & ~dead_i[i];
  end
endmodule

// File: rtl/serlink_rx.sv
module serlink_rx
  import serlink_pkg::*;
#(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           mode_hi_i,
  input  link_kind_e     kind_i,
  input  logic [W-1:0]   wires_i,
  output logic           out_valid_o,
  output logic [W-1:0]   out_data_o
);
  localparam int H = W / 2;

  logic [H-1:0] lo_q, half;
  logic         lo_en;
  logic [W-1:0] out_q, out_d;
  logic         out_en;
  logic         vld_q, vld_d;

  always_comb begin
    half   = mode_hi_i ? wires_i[W-1:H] : wires_i[H-1:0];
    lo_en  = (kind_i == LK_FIRST);
    out_en = (kind_i == LK_FULL) || (kind_i == LK_SECOND);
    out_d  = (kind_i == LK_SECOND) ? {half, lo_q} : wires_i;
    vld_d  = out_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      lo_q  <= '0;
      out_q <= '0;
    end else begin
      vld_q <= vld_d;
      if (lo_en)  lo_q  <= half;
      if (out_en) out_q <= out_d;
    end
  end

  assign out_valid_o = vld_q;
  assign out_data_o  = out_q;
endmodule

// File: rtl/serlink_adapter.sv
module serlink_adapter
  import serlink_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_serial_i,
  input  logic         cfg_use_hi_i,
  input  logic [W-1:0] wire_dead_i,
  input  logic         in_valid_i,
  input  logic [W-1:0] in_data_i,
  output logic         in_ready_o,
  output logic         out_valid_o,
  output logic [W-1:0] out_data_o
);
  logic         mode_ser, mode_hi, tx_pend, quiet;
  link_kind_e   link_kind;
  logic [W-1:0] tx_wires, rx_wires;

  assign quiet = ~tx_pend & (link_kind == LK_IDLE) & ~in_valid_i;

  serlink_mode u_mode (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_serial_i (cfg_serial_i),
    .cfg_use_hi_i (cfg_use_hi_i),
    .quiet_i      (quiet),
    .mode_ser_o   (mode_ser),
    .mode_hi_o    (mode_hi)
  );

  serlink_tx #(.W(W)) u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_ser_i (mode_ser),
    .mode_hi_i  (mode_hi),
    .in_valid_i (in_valid_i),
    .in_data_i  (in_data_i),
    .in_ready_o (in_ready_o),
    .pend_o     (tx_pend),
    .kind_o     (link_kind),
    .wires_o    (tx_wires)
  );

  serlink_chan #(.W(W)) u_chan (
    .tx_wires_i (tx_wires),
    .dead_i     (wire_dead_i),
    .rx_wires_o (rx_wires)
  );

  serlink_rx #(.W(W)) u_rx (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_hi_i   (mode_hi),
    .kind_i      (link_kind),
    .wires_i     (rx_wires),
    .out_valid_o (out_valid_o),
    .out_data_o  (out_data_o)
  );
endmodule

// File: rtl/serlink_chk.sv
module serlink_chk
  import serlink_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic       out_valid,
  input logic       mode_ser,
  input logic       mode_hi,
  input logic       tx_pend,
  input link_kind_e link_kind
);
  a_r4_stall_after_serial: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && mode_ser) |=> !in_ready);

  a_r4_no_stall_full: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !mode_ser) |=> in_ready);

  a_r2_full_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !mode_ser) |=> ##1 out_valid);

  a_r3_serial_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && mode_ser) |=> ##2 out_valid);

  a_r3_beat_order: assert property (@(posedge clk) disable iff (!rst_n)
    (link_kind == LK_FIRST) |=> (link_kind == LK_SECOND));

  a_r7_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_pend || link_kind != LK_IDLE || in_valid) |=> ($stable(mode_ser) && $stable(mode_hi)));

  a_r8_output_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_ser && out_valid) |=> !out_valid);
endmodule

bind serlink_adapter serlink_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid_i),
  .in_ready  (in_ready_o),
  .out_valid (out_valid_o),
  .mode_ser  (mode_ser),
  .mode_hi   (mode_hi),
  .tx_pend   (tx_pend),
  .link_kind (link_kind)
);

// File: tb/sim_serlink_adapter.sv
`timescale 1ns/1ps
module sim_serlink_adapter;
  localparam int W = 32;
  localparam int H = W / 2;

  logic         clk, rst_n, cfg_ser, cfg_hi, in_valid;
  logic [W-1:0] dead, in_data;
  logic         in_ready, out_valid;
  logic [W-1:0] out_data;

  serlink_adapter #(.W(W)) u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_serial_i (cfg_ser),
    .cfg_use_hi_i (cfg_hi),
    .wire_dead_i  (dead),
    .in_valid_i   (in_valid),
    .in_data_i    (in_data),
    .in_ready_o   (in_ready),
    .out_valid_o  (out_valid),
    .out_data_o   (out_data)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int cycle, n_chk, n_fail;
  bit m_ser, m_hi, m_pend, m_linkv;
  logic [W-1:0] q_data[$];
  int q_due[$];
  string tag;

  task automatic check(bit ok, string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] predict(logic [W-1:0] d);
    logic [H-1:0] sel;
    if (!m_ser) return d & ~dead;
    sel = m_hi ? dead[W-1:H] : dead[H-1:0];
    return {d[W-1:H] & ~sel, d[H-1:0] & ~sel};
  endfunction

  // One clock: drive after a falling edge, step the model, check after the next falling edge
  task automatic tick(input bit v, input logic [W-1:0] d, output bit acc);
    bit quiet, n_pend, n_linkv;
    in_valid = v;
    in_data  = d;
    #1;
    check(in_ready == !m_pend, "R4", "in_ready", W'(in_ready), W'(!m_pend));
    acc     = v && !m_pend;
    quiet   = !m_pend && !m_linkv && !v;
    if (acc) begin
      q_data.push_back(predict(d));
      q_due.push_back(cycle + 1 + (m_ser ? 2 : 1));
    end
    n_pend  = acc && m_ser;
    n_linkv = acc || m_pend;
    if (quiet) begin
      m_ser = cfg_ser;
      m_hi  = cfg_hi;
    end
    m_pend  = n_pend;
    m_linkv = n_linkv;
    @(posedge clk);
    cycle++;
    @(negedge clk);
    while (q_due.size() > 0 && q_due[0] < cycle) begin
      check(1'b0, tag, "missed delivery", W'(0), q_data[0]);
      void'(q_due.pop_front());
      void'(q_data.pop_front());
    end
    if (q_due.size() > 0 && q_due[0] == cycle) begin
      check(out_valid == 1'b1, tag, "out_valid", W'(out_valid), W'(1));
      check(out_data == q_data[0], tag, "out_data", out_data, q_data[0]);
      void'(q_due.pop_front());
      void'(q_data.pop_front());
    end else begin
      check(out_valid == 1'b0, tag, "out_valid idle", W'(out_valid), W'(0));
    end
  endtask

  task automatic send(input logic [W-1:0] d);
    bit a;
    do tick(1'b1, d, a); while (!a);
  endtask

  task automatic idle(input int n);
    bit a;
    for (int i = 0; i < n; i++) tick(1'b0, '0, a);
  endtask

  initial begin
    n_fail = 0;
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R2 watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    n_chk = 0; cycle = 0;
    m_ser = 0; m_hi = 0; m_pend = 0; m_linkv = 0;
    rst_n = 0; cfg_ser = 0; cfg_hi = 0; dead = '0; in_valid = 0; in_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #0.1;
    check(in_ready == 1'b1, "R1", "in_ready after reset", W'(in_ready), W'(1));
    check(out_valid == 1'b0, "R1", "out_valid after reset", W'(out_valid), W'(0));

    // R1 default mode is full width: a flit arrives after two edges
    tag = "R1";
    send(32'hC001_D00D);
    idle(3);

    // R2 full-width back-to-back patterns
    tag = "R2";
    send(32'hFFFF_FFFF); send(32'h0000_0000); send(32'hA5A5_5A5A);
    send(32'h1234_5678);
    for (int i = 0; i < W; i += 3) send(32'h1 << i);
    idle(3);

    // R6 dead wires clear bits in full-width mode
    tag = "R6";
    dead = 32'h0001_0100;
    send(32'hFFFF_FFFF); send(32'h8765_4321);
    idle(3);
    dead = '0;

    // R7 request serial mode while streaming: held until a quiet edge
    tag = "R7";
    send(32'h1111_1111); send(32'h2222_2222);
    cfg_ser = 1'b1;
    send(32'h3333_3333); send(32'h4444_4444);
    idle(4);
    send(32'h5555_AAAA);
    idle(4);

    // R3 and R8 serial on the low half, valid held high
    tag = "R8";
    send(32'hDEAD_BEEF); send(32'h0F0F_F0F0); send(32'hFFFF_0000);
    send(32'h0000_FFFF);
    idle(4);
    tag = "R3";
    send(32'hCAFE_F00D);
    idle(4);

    // R5 use high wires with the low half dead, then low wires with the high half dead
    tag = "R5";
    cfg_hi = 1'b1;
    idle(2);
    dead = 32'h0000_FFFF;
    send(32'h89AB_CDEF); send(32'hFFFF_FFFF); send(32'h7654_3210);
    idle(4);
    dead = '0;
    cfg_hi = 1'b0;
    idle(2);
    dead = 32'hFFFF_0000;
    send(32'h89AB_CDEF); send(32'hFFFF_FFFF);
    idle(4);

    // R6 dead wire on the used half clears that bit in both halves
    tag = "R6";
    dead = 32'h0000_0010;
    send(32'hFFFF_FFFF);
    idle(4);
    dead = '0;

    // R2 back to full width after a quiet gap
    tag = "R2";
    cfg_ser = 1'b0;
    idle(2);
    send(32'h0BAD_CAFE); send(32'hFACE_B00C);
    idle(4);

    check(q_due.size() == 0, "R2", "undelivered flits", W'(q_due.size()), W'(0));
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule